// File: doc/BRIEF.md
# I2C Command-Pointer Slave

This block is an I2C/SMBus slave engine that runs on a fast system clock and oversamples the SCL and SDA lines. Each line passes through a two-flop synchronizer and a majority window, so short spikes are dropped before any edge is seen. The engine recognises START, repeated START and STOP. It accepts the 7-bit address `0011` followed by three strap inputs. It pulls SDA low in the ninth clock to acknowledge the address and every byte it receives. SDA is driven as open drain: `sda_oe` high means pull low.

After a write address, the first byte is a command byte. Its two low bits become a register pointer, and that pointer keeps its value across transactions. Later write bytes are issued to a register-bank port as one-cycle write strobes. A read, either on its own or after a repeated START, streams the selected register MSB first. The register is sampled again for every byte and the index never advances. A STOP or START at any point abandons the transfer in progress. A byte whose acknowledge clock has not finished is never written.

Top module: `i2c_cmd_slave`

## Requirements
- R1: After synchronous active-low reset, `sda_oe`, `reg_wr` and `reg_rd` are 0 and the pointer `reg_idx` is 0.
- R2: A START is filtered SDA falling while filtered SCL is high, and it begins address reception. A STOP is SDA rising while SCL is high, and it returns the engine to idle with SDA released.
- R3: An address byte `{0011, strap_i[2:0], rw}` is acknowledged by driving SDA low for the whole ninth clock. rw=1 means read and rw=0 means write. Any other address gets no acknowledge, and SDA stays released until the next START or STOP.
- R4: The first byte after a write address is acknowledged. Bits [1:0] of that byte become `reg_idx` when its acknowledge clock ends. Bits [7:2] are ignored.
- R5: Every further write byte is acknowledged. When its acknowledge clock ends, it produces exactly one `reg_wr` pulse with `reg_wdata` equal to the byte and `reg_idx` equal to the pointer.
- R6: In a read, `reg_rdata` at `reg_idx` is captured at the end of the address acknowledge clock, and `reg_rd` pulses then. The byte is shifted out MSB first, with SDA low for each 0 bit.
- R7: A master acknowledge causes the same register to be captured again and sent again, with no change of index. A master not-acknowledge releases SDA, and the bus is then ignored until a START or STOP.
- R8: The pointer persists across STOP, so a read-only transfer reads the last selected register. A repeated START after the command byte switches to a read of that register.
- R9: A STOP inside a data byte abandons it without a write. Bytes that were already acknowledged stay committed.
- R10: SCL or SDA pulses shorter than `(FILT_LEN+1)/2` system clocks have no effect on decoding. The default `FILT_LEN` is 5.
- R11: `sda_oe` changes only in the cycle after a detected SCL fall, START or STOP. It is therefore never changed while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (oversamples the bus) |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| strap_i | input | 3 | Pin-strapped low address bits |
| sda_oe | output | 1 | 1 = pull SDA low |
| reg_idx | output | 2 | Register pointer / bank index |
| reg_wdata | output | 8 | Write data to register bank |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rd | output | 1 | One-cycle strobe when read data is captured |
| reg_rdata | input | 8 | Read data from bank at `reg_idx` |

## Verification
A wrong bit counter or state shows up within one SCL period, as an acknowledge in the wrong clock or a data bit driven during SCL high. Both are caught on every system clock while SCL is high. A corrupted pointer does not show until the next read or write strobe, so the read-only transfers after reset and after a STOP expose it on the first data bit. A filter that lets a glitch through produces either a false START or a shifted byte. That appears as a wrong write value in the same transaction.

// File: rtl/i2cs_pkg.sv
// Package: shared state encoding, bus event bundle and fixed address nibble
// for the I2C command-pointer slave. Assumes 7-bit addressing only.
package i2cs_pkg;

    localparam logic [3:0] ADDR_HI = 4'b0011;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_MACK
    } sl_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

endpackage

// File: rtl/i2cs_glitch_filter.sv
// Glitch filter: two-flop synchronizer followed by a FILT_LEN-sample majority
// vote. Assumes FILT_LEN is odd and at least 3; the idle bus level is high.
module i2cs_glitch_filter #(
    parameter int FILT_LEN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic line_o
);
    localparam int CW   = $clog2(FILT_LEN + 1);
    localparam int HALF = FILT_LEN / 2;

    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] win_q;
    logic [CW-1:0]       ones;
    logic                out_q;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], line_i};
    end

    // Keep the last FILT_LEN synchronized samples.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '1;
        else        win_q <= {win_q[FILT_LEN-2:0], sync_q[1]};
    end

    // Count the high samples in the window.
    always_comb begin
        ones = '0;
        for (int i = 0; i < FILT_LEN; i++) ones = ones + CW'(win_q[i]);
    end

    // Register the majority decision.
    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b1;
        else        out_q <= (ones > CW'(HALF));
    end

    assign line_o = out_q;
endmodule

// File: rtl/i2cs_bus_cond.sv
// Bus condition detector: turns filtered SCL/SDA into single-cycle SCL edge,
// START and STOP events. Assumes both inputs are already filtered and aligned.
module i2cs_bus_cond
    import i2cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    // Remember the previous filtered levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Decode edges and START/STOP from the level pairs.
    always_comb begin
        ev.scl_rise = scl_f & ~scl_q;
        ev.scl_fall = ~scl_f & scl_q;
        ev.start    = scl_f & scl_q & sda_q & ~sda_f;
        ev.stop     = scl_f & scl_q & ~sda_q & sda_f;
        ev.sda      = sda_f;
    end
endmodule

// File: rtl/i2cs_byte_fsm.sv
// Byte engine: address match, acknowledge generation, command pointer,
// write strobes and non-incrementing reads. Assumes reg_rdata is a
// combinational function of reg_idx and that the master never stretches.
module i2cs_byte_fsm
    import i2cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  bus_ev_t    ev,
    input  logic [2:0] strap_i,
    input  logic [7:0] reg_rdata,
    output logic       sda_oe,
    output logic [1:0] reg_idx,
    output logic [7:0] reg_wdata,
    output logic       reg_wr,
    output logic       reg_rd
);
    sl_state_t  state_q;
    logic [3:0] cnt_q;
    logic [7:0] sh_q;
    logic [6:0] tx_q;
    logic [1:0] ptr_q;
    logic [7:0] wd_q;
    logic       rw_q, mack_q, oe_q, wr_q, rd_q;

    wire ev_fall  = ev.scl_fall;
    wire ev_start = ev.start;
    wire ev_stop  = ev.stop;

    // Main sequencer: all state changes happen on bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sh_q    <= '0;
            tx_q    <= '0;
            ptr_q   <= '0;
            wd_q    <= '0;
            rw_q    <= 1'b0;
            mack_q  <= 1'b0;
            oe_q    <= 1'b0;
            wr_q    <= 1'b0;
            rd_q    <= 1'b0;
        end else begin
            wr_q <= 1'b0;
            rd_q <= 1'b0;
            if (ev.start) begin
                state_q <= ST_ADDR;
                cnt_q   <= '0;
                oe_q    <= 1'b0;
            end else if (ev.stop) begin
                state_q <= ST_IDLE;
                oe_q    <= 1'b0;
            end else begin
                case (state_q)
                    ST_ADDR, ST_CMD, ST_WDATA: begin
                        if (ev.scl_rise && cnt_q != 4'd8) begin
                            sh_q  <= {sh_q[6:0], ev.sda};
                            cnt_q <= cnt_q + 4'd1;
                        end else if (ev.scl_fall && cnt_q == 4'd8) begin
                            cnt_q <= '0;
                            if (state_q == ST_ADDR) begin
                                if (sh_q[7:1] == {ADDR_HI, strap_i}) begin
                                    rw_q    <= sh_q[0];
                                    oe_q    <= 1'b1;
                                    state_q <= ST_ADDR_ACK;
                                end else begin
                                    state_q <= ST_IDLE;
                                end
                            end else if (state_q == ST_CMD) begin
                                oe_q    <= 1'b1;
                                state_q <= ST_CMD_ACK;
                            end else begin
                                oe_q    <= 1'b1;
                                state_q <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            if (rw_q) begin
                                tx_q    <= reg_rdata[6:0];
                                oe_q    <= ~reg_rdata[7];
                                rd_q    <= 1'b1;
                                cnt_q   <= '0;
                                state_q <= ST_RDATA;
                            end else begin
                                oe_q    <= 1'b0;
                                state_q <= ST_CMD;
                            end
                        end
                    end
                    ST_CMD_ACK: begin
                        if (ev.scl_fall) begin
                            ptr_q   <= sh_q[1:0];
                            oe_q    <= 1'b0;
                            state_q <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (ev.scl_fall) begin
                            wd_q    <= sh_q;
                            wr_q    <= 1'b1;
                            oe_q    <= 1'b0;
                            state_q <= ST_WDATA;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            if (cnt_q == 4'd7) begin
                                oe_q    <= 1'b0;
                                state_q <= ST_MACK;
                            end else begin
                                oe_q  <= ~tx_q[6];
                                tx_q  <= {tx_q[5:0], 1'b0};
                                cnt_q <= cnt_q + 4'd1;
                            end
                        end
                    end
                    ST_MACK: begin
                        if (ev.scl_rise) begin
                            mack_q <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack_q) begin
                                tx_q    <= reg_rdata[6:0];
                                oe_q    <= ~reg_rdata[7];
                                rd_q    <= 1'b1;
                                cnt_q   <= '0;
                                state_q <= ST_RDATA;
                            end else begin
                                state_q <= ST_IDLE;
                            end
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_oe    = oe_q;
    assign reg_idx   = ptr_q;
    assign reg_wdata = wd_q;
    assign reg_wr    = wr_q;
    assign reg_rd    = rd_q;

    AST_OE_SCL_LOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(ev_fall) && !$past(ev_start) && !$past(ev_stop)) |-> $stable(oe_q)); // R11
    AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        ev_start |=> (state_q == ST_ADDR && !oe_q)); // R2
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_stop && !ev_start) |=> (state_q == ST_IDLE && !oe_q)); // R2
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !oe_q); // R3
    AST_WR_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_q |-> $past(ev_fall)); // R5
    AST_RD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_q |-> $past(ev_fall)); // R6
endmodule

// File: rtl/i2c_cmd_slave.sv
// Top: filters both bus lines, detects bus conditions and runs the byte
// engine. Assumes an external open-drain pad turns sda_oe into a low drive.
module i2c_cmd_slave #(
    parameter int FILT_LEN = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic [2:0] strap_i,
    output logic       sda_oe,
    output logic [1:0] reg_idx,
    output logic [7:0] reg_wdata,
    output logic       reg_wr,
    output logic       reg_rd,
    input  logic [7:0] reg_rdata
);
    import i2cs_pkg::*;

    localparam int NLINES = 2;

    logic [NLINES-1:0] raw_lines;
    logic [NLINES-1:0] filt_lines;
    bus_ev_t           ev;

    assign raw_lines = {scl_i, sda_i};

    // One filter per bus line.
    for (genvar g = 0; g < NLINES; g++) begin : g_filt
        i2cs_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw_lines[g]),
            .line_o (filt_lines[g])
        );
    end

    i2cs_bus_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_f (filt_lines[1]),
        .sda_f (filt_lines[0]),
        .ev    (ev)
    );

    i2cs_byte_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .strap_i   (strap_i),
        .reg_rdata (reg_rdata),
        .sda_oe    (sda_oe),
        .reg_idx   (reg_idx),
        .reg_wdata (reg_wdata),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd)
    );
endmodule

// File: tb/i2c_cmd_slave_tb_top.sv
module i2c_cmd_slave_tb_top;
    localparam int Q = 20;
    localparam logic [2:0] STRAP = 3'b101;
    localparam logic [7:0] A_W = {4'b0011, STRAP, 1'b0};
    localparam logic [7:0] A_R = {4'b0011, STRAP, 1'b1};

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic       sda_oe, reg_wr, reg_rd;
    logic [1:0] reg_idx;
    logic [7:0] reg_wdata, reg_rdata, in_val;
    logic [7:0] bank [0:3];
    wire        sda_line = ~(m_low | sda_oe);

    int    n_cmp = 0, n_bad = 0;
    bit    exp_drv = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R11";
    logic [9:0] wq[$];

    i2c_cmd_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap_i(STRAP), .sda_oe(sda_oe), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata)
    );

    // Bench-side register bank; index 0 is the live input value.
    assign reg_rdata = (reg_idx == 2'd0) ? in_val : bank[reg_idx];
    always @(posedge clk) begin
        if (!rst_n) begin
            bank[0] <= 8'h00; bank[1] <= 8'h00; bank[2] <= 8'hF0; bank[3] <= 8'hFF;
        end else if (reg_wr && reg_idx != 2'd0) begin
            bank[reg_idx] <= reg_wdata;
        end
    end

    // Per-clock reference comparison.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (scl) begin
                n_cmp++;
                if (sda_oe !== exp_drv) begin
                    n_bad++;
                    $display("FAIL %s: sda_oe=%0b expected %0b at %0t", cur_req, sda_oe, exp_drv, $time);
                end
            end
            if (reg_wr) begin
                n_cmp++;
                if (wq.size() == 0) begin
                    n_bad++;
                    $display("FAIL R5: unexpected write idx=%0d data=%02h expected none", reg_idx, reg_wdata);
                end else begin
                    logic [9:0] e;
                    e = wq.pop_front();
                    if ({reg_idx, reg_wdata} !== e) begin
                        n_bad++;
                        $display("FAIL R5: write %03h expected %03h", {reg_idx, reg_wdata}, e);
                    end
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic b_start();
        cur_req = "R2"; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0;
    endtask

    task automatic b_rstart();
        cur_req = "R8"; tick(Q); m_low = 1'b0; tick(Q); scl = 1'b1;
        tick(Q); m_low = 1'b1; tick(Q); scl = 1'b0;
    endtask

    task automatic b_stop();
        cur_req = "R2"; tick(Q); m_low = 1'b1; tick(Q); scl = 1'b1;
        tick(Q); m_low = 1'b0; tick(2 * Q);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n, input bit glitch, input string req);
        cur_req = req;
        exp_drv = 1'b0;
        for (int i = 7; i > 7 - n; i--) begin
            tick(Q); m_low = ~b[i];
            if (glitch) begin tick(4); scl = 1'b1; tick(2); scl = 1'b0; tick(Q - 6); end
            else tick(Q);
            scl = 1'b1;
            if (glitch) begin tick(Q); m_low = ~m_low; tick(2); m_low = ~m_low; tick(Q - 2); end
            else tick(2 * Q);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input bit ack_exp, input bit glitch, input string req);
        send_bits(b, 8, glitch, req);
        tick(Q); m_low = 1'b0; tick(Q);
        exp_drv = ack_exp; cur_req = req; scl = 1'b1;
        tick(Q); check(req, int'(!sda_line), int'(ack_exp));
        tick(Q); scl = 1'b0; exp_drv = 1'b0;
    endtask

    task automatic recv_byte(input logic [7:0] e, input bit mack, input logic [7:0] new_in, input string req);
        logic [7:0] got;
        got = '0;
        for (int i = 7; i >= 0; i--) begin
            if (i == 7) begin tick(Q); m_low = 1'b0; tick(Q); end
            else tick(2 * Q);
            exp_drv = ~e[i]; cur_req = req; scl = 1'b1;
            tick(Q); got[i] = sda_line;
            if (i == 7) in_val = new_in;
            tick(Q); scl = 1'b0; exp_drv = 1'b0;
        end
        check(req, int'(got), int'(e));
        cur_req = "R7";
        tick(Q); m_low = mack; tick(Q); scl = 1'b1; tick(2 * Q); scl = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        in_val = 8'hA5;
        tick(10);
        rst_n = 1'b1;
        tick(2);
        // R1: reset state at the ports
        check("R1", int'(sda_oe), 0);
        check("R1", int'(reg_wr), 0);
        check("R1", int'(reg_rd), 0);
        check("R1", int'(reg_idx), 0);
        tick(Q);

        // R1/R8: read-only after reset reads index 0; R7 NACK then ignored clocks
        b_start();
        send_byte(A_R, 1'b1, 1'b0, "R3");
        recv_byte(8'hA5, 1'b0, 8'hA5, "R6");
        send_bits(8'hFF, 8, 1'b0, "R7");
        send_bits(8'hFF, 1, 1'b0, "R7");
        b_stop();

        // R4/R5: command then two writes to index 1
        b_start();
        send_byte(A_W, 1'b1, 1'b0, "R3");
        send_byte(8'h01, 1'b1, 1'b0, "R4");
        wq.push_back({2'd1, 8'h3C});
        send_byte(8'h3C, 1'b1, 1'b0, "R5");
        wq.push_back({2'd1, 8'h5A});
        send_byte(8'h5A, 1'b1, 1'b0, "R5");
        b_stop();
        check("R4", int'(reg_idx), 1);
        check("R5", int'(bank[1]), 8'h5A);

        // R4 upper bits ignored, R8 repeated START read of index 2
        b_start();
        send_byte(A_W, 1'b1, 1'b0, "R3");
        send_byte(8'hF6, 1'b1, 1'b0, "R4");
        wq.push_back({2'd2, 8'h81});
        send_byte(8'h81, 1'b1, 1'b0, "R5");
        b_rstart();
        send_byte(A_R, 1'b1, 1'b0, "R3");
        recv_byte(8'h81, 1'b0, 8'hA5, "R8");
        b_stop();
        check("R4", int'(reg_idx), 2);

        // R7: multi-byte read of index 0, re-sampled, no increment
        b_start();
        send_byte(A_W, 1'b1, 1'b0, "R3");
        send_byte(8'h00, 1'b1, 1'b0, "R4");
        b_stop();
        in_val = 8'h11;
        b_start();
        send_byte(A_R, 1'b1, 1'b0, "R3");
        recv_byte(8'h11, 1'b1, 8'h22, "R7");
        recv_byte(8'h22, 1'b1, 8'h33, "R7");
        recv_byte(8'h33, 1'b0, 8'h44, "R7");
        send_bits(8'hFF, 8, 1'b0, "R7");
        send_bits(8'hFF, 1, 1'b0, "R7");
        b_stop();
        check("R7", int'(reg_idx), 0);

        // R3: wrong address and general call are not acknowledged, bytes ignored
        b_start();
        send_byte({4'b0011, 3'b100, 1'b0}, 1'b0, 1'b0, "R3");
        send_byte(8'h55, 1'b0, 1'b0, "R3");
        b_stop();
        b_start();
        send_byte(8'h00, 1'b0, 1'b0, "R3");
        b_stop();
        check("R3", int'(reg_idx), 0);

        // R9: committed byte kept, partial byte abandoned by STOP
        b_start();
        send_byte(A_W, 1'b1, 1'b0, "R3");
        send_byte(8'h01, 1'b1, 1'b0, "R4");
        wq.push_back({2'd1, 8'h77});
        send_byte(8'h77, 1'b1, 1'b0, "R9");
        send_bits(8'h99, 4, 1'b0, "R9");
        tick(Q); m_low = 1'b0;
        b_stop();
        b_start();
        send_byte(A_R, 1'b1, 1'b0, "R8");
        recv_byte(8'h77, 1'b0, 8'h44, "R9");
        b_stop();

        // R10: glitches on SCL (low phase) and SDA (high phase) are rejected
        b_start();
        send_byte(A_W, 1'b1, 1'b0, "R3");
        send_byte(8'h03, 1'b1, 1'b0, "R4");
        wq.push_back({2'd3, 8'hC3});
        send_byte(8'hC3, 1'b1, 1'b1, "R10");
        b_stop();
        b_start();
        send_byte(A_R, 1'b1, 1'b0, "R8");
        recv_byte(8'hC3, 1'b0, 8'h44, "R10");
        b_stop();

        tick(Q);
        check("R5", wq.size(), 0);
        check("R2", int'(sda_oe), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule